// File: doc/BRIEF.md
# Interrupt Source Masking and Routing Register File

This block takes a set of level-sensitive hardware interrupt lines plus a bank of software-raised interrupt bits and turns them into two things: a fast-interrupt request line, and a masked vector of normal-interrupt sources that a downstream priority unit consumes. Each source is routed either to the fast path or to the normal path by a routing-select register. Only the normal path is gated by the enable mask.

Software reaches the block through a simple word-addressed register port. Writes take effect on the clock edge where `busWr` is high. Reads are combinational from `busAddr` and have no side effects. The enable mask and the software bits each have a set address and a separate clear address, so one source can be changed without a read-modify-write sequence. A single protection flag and a read-only identification window complete the map. Vector slots and priority arbitration belong to the neighbouring unit.

Top module: `intsrc_mask_top`

## Requirements
- R1: The raw status, read at word address 2, equals the hardware lines as captured on the previous clock edge, ORed with the software bits. A change on `hwIrq` is not visible before the next rising edge.
- R2: The IRQ status, read at word address 0, and the `irqVec` output both equal raw AND enable AND NOT routing-select.
- R3: The FIQ status, read at word address 1, equals raw AND routing-select, whatever the enable mask holds. `fiqOut` is high exactly when that status is non-zero.
- R4: The routing-select register at word address 3 is written whole and reads back what was written. A bit set to 1 sends that source to the fast path.
- R5: A write to word address 4 ORs the data into the enable mask. A write to word address 5 clears every enable bit that is 1 in the data. Reading word address 4 returns the mask.
- R6: A write to word address 6 ORs the data into the software bits. A write to word address 7 clears every software bit that is 1 in the data. Reading word address 6 returns the software bits.
- R7: The protection flag at word address 8 stores only data bit 0. It reads back as that bit, with all other bits zero.
- R8: Writes to word addresses 0, 1 and 2, to the identification window and to any undefined address change no state. Reads of word addresses 5, 7 and any undefined address return zero.
- R9: Word addresses 0x3F8 to 0x3FF (byte 0xFE0 to 0xFFF) each return one identification byte, in address order: 0x90, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: After reset, every register and the input capture stage are zero, so all statuses, `irqVec` and `fiqOut` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hwIrq | input | NUM_SRC | Level-sensitive hardware interrupt lines, synchronous to clk |
| busAddr | input | ADDR_W | Word address of the register access |
| busWr | input | 1 | Write strobe, one cycle per write |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr, combinational |
| irqVec | output | NUM_SRC | Enabled normal-path sources, sent to the priority unit |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
The assertions assume that `hwIrq` is already synchronous to `clk`, because the single capture stage is not a synchronizer. They also assume that each write strobe lasts exactly one cycle, with the address and data held steady around the edge. The bench drives every input only on falling edges and drops `busWr` after one cycle. It changes the hardware lines only between register accesses, so the expected raw value is always the pattern present at the last rising edge. The random accesses are weighted toward the set and clear addresses, the read-only status words and a few unmapped words, so each write path and each ignore path gets hit many times.

// File: rtl/intsrc_mask_pkg.sv
package intsrc_mask_pkg;

  localparam int OFF_IRQ_STAT  = 0;
  localparam int OFF_FIQ_STAT  = 1;
  localparam int OFF_RAW_STAT  = 2;
  localparam int OFF_ROUTE     = 3;
  localparam int OFF_EN_SET    = 4;
  localparam int OFF_EN_CLR    = 5;
  localparam int OFF_SOFT_SET  = 6;
  localparam int OFF_SOFT_CLR  = 7;
  localparam int OFF_PROT      = 8;

  typedef struct packed {
    logic routeWr;
    logic enSet;
    logic enClr;
    logic softSet;
    logic softClr;
    logic protWr;
  } wr_strobe_t;

  typedef enum logic [3:0] {
    RD_ZERO, RD_IRQ, RD_FIQ, RD_RAW, RD_ROUTE, RD_EN, RD_SOFT, RD_PROT, RD_ID
  } rd_sel_t;

  function automatic logic [7:0] idByte(input logic [2:0] idx);
    case (idx)
      3'd0: idByte = 8'h90;
      3'd1: idByte = 8'h11;
      3'd2: idByte = 8'h04;
      3'd3: idByte = 8'h00;
      3'd4: idByte = 8'h0D;
      3'd5: idByte = 8'hF0;
      3'd6: idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/intsrc_mask_ctrl.sv
module intsrc_mask_ctrl
  import intsrc_mask_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output wr_strobe_t        wrStb,
  output rd_sel_t           rdSel,
  output logic [2:0]        idIdx
);

  localparam int ID_TAG_W = ADDR_W - 3;

  logic inIdWindow;
  assign inIdWindow = (busAddr[ADDR_W-1:3] == {ID_TAG_W{1'b1}});
  assign idIdx      = busAddr[2:0];

  always_comb begin
    wrStb = '0;
    if (busWr) begin
      wrStb.routeWr = (busAddr == ADDR_W'(OFF_ROUTE));
      wrStb.enSet   = (busAddr == ADDR_W'(OFF_EN_SET));
      wrStb.enClr   = (busAddr == ADDR_W'(OFF_EN_CLR));
      wrStb.softSet = (busAddr == ADDR_W'(OFF_SOFT_SET));
      wrStb.softClr = (busAddr == ADDR_W'(OFF_SOFT_CLR));
      wrStb.protWr  = (busAddr == ADDR_W'(OFF_PROT));
    end
  end

  always_comb begin
    rdSel = RD_ZERO;
    if (inIdWindow) begin
      rdSel = RD_ID;
    end else begin
      case (busAddr)
        ADDR_W'(OFF_IRQ_STAT): rdSel = RD_IRQ;
        ADDR_W'(OFF_FIQ_STAT): rdSel = RD_FIQ;
        ADDR_W'(OFF_RAW_STAT): rdSel = RD_RAW;
        ADDR_W'(OFF_ROUTE):    rdSel = RD_ROUTE;
        ADDR_W'(OFF_EN_SET):   rdSel = RD_EN;
        ADDR_W'(OFF_SOFT_SET): rdSel = RD_SOFT;
        ADDR_W'(OFF_PROT):     rdSel = RD_PROT;
        default:               rdSel = RD_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/intsrc_mask_dp.sv
module intsrc_mask_dp
  import intsrc_mask_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] hwIrq,
  input  wr_strobe_t         wrStb,
  input  logic [DATA_W-1:0]  busWdata,
  input  rd_sel_t            rdSel,
  input  logic [2:0]         idIdx,
  output logic [DATA_W-1:0]  busRdata,
  output logic [NUM_SRC-1:0] irqVec,
  output logic               fiqOut,
  output logic [NUM_SRC-1:0] enMask,
  output logic [NUM_SRC-1:0] selMask,
  output logic [NUM_SRC-1:0] softMask,
  output logic [NUM_SRC-1:0] rawMask
);

  logic [NUM_SRC-1:0] hwSync;
  logic [NUM_SRC-1:0] enNext;
  logic [NUM_SRC-1:0] softNext;
  logic [NUM_SRC-1:0] fiqStat;
  logic [NUM_SRC-1:0] wrBits;
  logic               protBit;

  assign wrBits = busWdata[NUM_SRC-1:0];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign enNext[g]   = (wrStb.enSet   && wrBits[g]) ? 1'b1 :
                         (wrStb.enClr   && wrBits[g]) ? 1'b0 : enMask[g];
    assign softNext[g] = (wrStb.softSet && wrBits[g]) ? 1'b1 :
                         (wrStb.softClr && wrBits[g]) ? 1'b0 : softMask[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hwSync   <= '0;
      enMask   <= '0;
      softMask <= '0;
      selMask  <= '0;
      protBit  <= 1'b0;
    end else begin
      hwSync   <= hwIrq;
      enMask   <= enNext;
      softMask <= softNext;
      if (wrStb.routeWr) selMask <= wrBits;
      if (wrStb.protWr)  protBit <= busWdata[0];
    end
  end

  assign rawMask = hwSync | softMask;
  assign fiqStat = rawMask & selMask;
  assign irqVec  = rawMask & enMask & ~selMask;
  assign fiqOut  = |fiqStat;

  always_comb begin
    case (rdSel)
      RD_IRQ:   busRdata = DATA_W'(irqVec);
      RD_FIQ:   busRdata = DATA_W'(fiqStat);
      RD_RAW:   busRdata = DATA_W'(rawMask);
      RD_ROUTE: busRdata = DATA_W'(selMask);
      RD_EN:    busRdata = DATA_W'(enMask);
      RD_SOFT:  busRdata = DATA_W'(softMask);
      RD_PROT:  busRdata = DATA_W'(protBit);
      RD_ID:    busRdata = DATA_W'(idByte(idIdx));
      default:  busRdata = '0;
    endcase
  end

endmodule

// File: rtl/intsrc_mask_top.sv
module intsrc_mask_top
  import intsrc_mask_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] hwIrq,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic [NUM_SRC-1:0] irqVec,
  output logic               fiqOut
);

  wr_strobe_t         wrStb;
  rd_sel_t            rdSel;
  logic [2:0]         idIdx;
  logic [NUM_SRC-1:0] enMask;
  logic [NUM_SRC-1:0] selMask;
  logic [NUM_SRC-1:0] softMask;
  logic [NUM_SRC-1:0] rawMask;

  intsrc_mask_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busAddr (busAddr),
    .busWr   (busWr),
    .wrStb   (wrStb),
    .rdSel   (rdSel),
    .idIdx   (idIdx)
  );

  intsrc_mask_dp #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .hwIrq    (hwIrq),
    .wrStb    (wrStb),
    .busWdata (busWdata),
    .rdSel    (rdSel),
    .idIdx    (idIdx),
    .busRdata (busRdata),
    .irqVec   (irqVec),
    .fiqOut   (fiqOut),
    .enMask   (enMask),
    .selMask  (selMask),
    .softMask (softMask),
    .rawMask  (rawMask)
  );

endmodule

// File: rtl/intsrc_mask_chk.sv
module intsrc_mask_chk
  import intsrc_mask_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 10
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] hwIrq,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWr,
  input logic [DATA_W-1:0]  busWdata,
  input logic [NUM_SRC-1:0] irqVec,
  input logic               fiqOut,
  input logic [NUM_SRC-1:0] enMask,
  input logic [NUM_SRC-1:0] selMask,
  input logic [NUM_SRC-1:0] softMask,
  input logic [NUM_SRC-1:0] rawMask
);

  logic [NUM_SRC-1:0] wBits;
  assign wBits = busWdata[NUM_SRC-1:0];

  assert_raw_capture_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (rawMask == ($past(hwIrq) | softMask)));

  assert_irq_gated_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((irqVec & selMask) == '0) && ((irqVec & ~enMask) == '0));

  assert_fiq_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    !fiqOut |-> ((rawMask & selMask) == '0));

  assert_en_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(OFF_EN_SET)) |=>
      (((enMask & $past(wBits)) == $past(wBits)) &&
       ((enMask & ~$past(wBits)) == ($past(enMask) & ~$past(wBits)))));

  assert_en_clr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(OFF_EN_CLR)) |=>
      (((enMask & $past(wBits)) == '0) &&
       ((enMask & ~$past(wBits)) == ($past(enMask) & ~$past(wBits)))));

  assert_soft_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(OFF_SOFT_SET)) |=>
      ((softMask & $past(wBits)) == $past(wBits)));

  assert_soft_clr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(OFF_SOFT_CLR)) |=>
      ((softMask & $past(wBits)) == '0));

  assert_status_wr_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr <= ADDR_W'(OFF_RAW_STAT)) |=>
      ($stable(enMask) && $stable(selMask) && $stable(softMask)));

endmodule

bind intsrc_mask_top intsrc_mask_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) chk_i (.*);

// File: tb/intsrc_mask_top_tb_top.sv
module intsrc_mask_top_tb_top;

  localparam int NS = 32;
  localparam int DW = 32;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] hwIrq = '0;
  logic [AW-1:0] busAddr = '0;
  logic          busWr = 1'b0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic [NS-1:0] irqVec;
  logic          fiqOut;

  int errCnt = 0;
  int chkCnt = 0;
  bit finished = 0;

  logic [NS-1:0] mHw = '0, mEn = '0, mSel = '0, mSoft = '0;
  logic          mProt = 1'b0;
  logic [7:0]    idTab [8] = '{8'h90, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  intsrc_mask_top #(.NUM_SRC(NS), .DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .hwIrq(hwIrq), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .irqVec(irqVec), .fiqOut(fiqOut)
  );

  always #10 clk = ~clk;

  function automatic logic [NS-1:0] expRaw();  return mHw | mSoft; endfunction
  function automatic logic [NS-1:0] expIrq();  return expRaw() & mEn & ~mSel; endfunction
  function automatic logic [NS-1:0] expFiq();  return expRaw() & mSel; endfunction

  function automatic logic [DW-1:0] expRead(input logic [AW-1:0] a);
    if (a >= 10'h3F8) return DW'(idTab[a[2:0]]);
    case (a)
      10'd0: return DW'(expIrq());
      10'd1: return DW'(expFiq());
      10'd2: return DW'(expRaw());
      10'd3: return DW'(mSel);
      10'd4: return DW'(mEn);
      10'd6: return DW'(mSoft);
      10'd8: return DW'(mProt);
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    busAddr = a; busWr = 1'b1; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
    case (a)
      10'd3: mSel = d;
      10'd4: mEn = mEn | d;
      10'd5: mEn = mEn & ~d;
      10'd6: mSoft = mSoft | d;
      10'd7: mSoft = mSoft & ~d;
      10'd8: mProt = d[0];
      default: ;
    endcase
  endtask

  task automatic readChk(input string tag, input logic [AW-1:0] a);
    @(negedge clk);
    busAddr = a; busWr = 1'b0;
    #2;
    check(tag, busRdata, expRead(a));
  endtask

  task automatic outChk(input string tag);
    @(negedge clk);
    #2;
    check({tag, " irqVec R2"}, DW'(irqVec), DW'(expIrq()));
    check({tag, " fiqOut R3"}, DW'(fiqOut), DW'(expFiq() != '0));
  endtask

  task automatic setHw(input logic [NS-1:0] v);
    @(negedge clk);
    hwIrq = v;
    busAddr = 10'd2;
    #2;
    check("R1 raw before edge", busRdata, DW'(expRaw()));
    @(negedge clk);
    mHw = v;
  endtask

  task automatic allChk(input string tag);
    for (int a = 0; a <= 8; a++) readChk(tag, AW'(a));
    outChk(tag);
  endtask

  initial begin : watchdog
    #(20 * 200000);
    if (!finished) begin
      errCnt++; chkCnt++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin : stim
    int seed;
    logic [AW-1:0] addrPool [12] = '{10'd0, 10'd1, 10'd2, 10'd3, 10'd4, 10'd5,
                                     10'd6, 10'd7, 10'd8, 10'd9, 10'h2A, 10'h3FB};
    seed = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    #2;
    check("R10 reset irqVec", DW'(irqVec), '0);
    check("R10 reset fiqOut", DW'(fiqOut), '0);
    rstN = 1'b1;
    allChk("R10 reset state");

    for (int i = 0; i < 8; i++) readChk("R9 id byte", AW'(10'h3F8 + i));

    setHw(32'h0000_00F0);
    readChk("R1 raw after edge", 10'd2);
    doWrite(10'd4, 32'h0000_0030);
    readChk("R5 enable set", 10'd4);
    outChk("R2 enabled hw");
    doWrite(10'd4, 32'h0000_0300);
    readChk("R5 enable set accumulates", 10'd4);
    doWrite(10'd5, 32'h0000_0110);
    readChk("R5 enable clear", 10'd4);
    readChk("R8 clear addr reads zero", 10'd5);

    doWrite(10'd6, 32'h8000_0001);
    readChk("R6 soft set", 10'd6);
    readChk("R1 raw with soft", 10'd2);
    doWrite(10'd7, 32'h0000_0001);
    readChk("R6 soft clear", 10'd6);
    readChk("R8 soft clear reads zero", 10'd7);

    doWrite(10'd5, 32'hFFFF_FFFF);
    doWrite(10'd3, 32'h8000_0020);
    readChk("R4 route readback", 10'd3);
    readChk("R3 fiq with enable off", 10'd1);
    outChk("R3 fiq independent of enable");
    readChk("R2 irq status routed away", 10'd0);

    doWrite(10'd8, 32'hFFFF_FFFF);
    readChk("R7 prot bit0 only", 10'd8);
    doWrite(10'd8, 32'h0000_0002);
    readChk("R7 prot ignores bit1", 10'd8);

    doWrite(10'd0, 32'hFFFF_FFFF);
    doWrite(10'd1, 32'hFFFF_FFFF);
    doWrite(10'd2, 32'hFFFF_FFFF);
    doWrite(10'h3FC, 32'hFFFF_FFFF);
    doWrite(10'h2A, 32'hFFFF_FFFF);
    allChk("R8 ignored writes");
    readChk("R8 undefined read", 10'h2A);
    readChk("R9 id after write", 10'h3FC);

    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom % 5);
      if (op == 0) setHw($urandom);
      else doWrite(addrPool[$urandom % 12], $urandom & (($urandom % 2 == 0) ? 32'hFFFF_FFFF : 32'h0F0F_00FF));
      if (it % 4 == 0) allChk("R1 R2 R3 R4 R5 R6 random");
      else begin
        readChk("R2 random irq", 10'd0);
        readChk("R3 random fiq", 10'd1);
        outChk("R2 R3 random outputs");
      end
    end
    readChk("R7 random prot", 10'd8);
    readChk("R8 random undefined", 10'h2A);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule